// File: doc/BRIEF.md
# Embedded-Clock Frame Lock Receiver

This block takes a recovered serial bit stream, one bit per cycle in which the bit-rate enable is high, and finds the 28-bit frame boundary without any training sequence. Each frame carries a fixed one-then-zero clock pair, 24 payload bits, a balance bit and an integrity bit. The receiver tries one bit offset at a time. It accepts an offset once eight frames in a row show the clock pair and pass the parity check. It then raises the lock flag and delivers de-inverted 24-bit words, each with a one-cycle strobe.

The receiver is built around a three-state machine. PWRDN is entered whenever powerdown is high and left for HUNT when powerdown falls. HUNT moves to LOCKED on the eighth consecutive good frame, and it slips one bit to the next offset on any bad frame. LOCKED returns to HUNT, slipping one bit, on the first frame whose clock pair is wrong. After lock, a parity failure alone keeps the lock and increments a saturating error count. The output enable and powerdown both gate the word and strobe outputs. The lock flag always shows the true lock state.

Top module: `ecl_lock_rx`

## Requirements
- R1: A bit is taken only in a cycle with `bit_en_i` high. Frame bits arrive in this order: clock-high (1), clock-low (0), payload bits d0 to d23, balance bit, integrity bit. The integrity bit makes the XOR of every bit after the clock pair (payload as sent, balance, integrity) equal 0.
- R2: In HUNT, a frame is good when it has the clock pair 1,0 and passes parity. Eight consecutive good frames at one offset give lock. A bad frame resets the run and moves the frame window one bit later.
- R3: In LOCKED, a frame whose clock pair is not 1,0 drops `lock_o` at the edge that takes that frame's last bit. The search then resumes one bit later, so after a one-bit stream slip the receiver relocks at the new offset in eight frames.
- R4: `lock_o` rises in the same cycle as the first `valid_o` pulse and its word. `valid_o` is a one-cycle pulse per locked frame, and it is never high while `lock_o` is low.
- R5: When the balance bit is 1, the payload was sent inverted, and `word_o` carries it re-inverted. When the balance bit is 0, the payload passes unchanged. `word_o[i]` is d<i>.
- R6: In LOCKED, a frame with a good clock pair but failed parity keeps lock and still delivers its word. It also increments `err_cnt_o`, which saturates at 2^ERR_W-1 (255 by default).
- R7: With `oe_i` low, `drive_en_o` is 0, `word_o` reads 0 and `valid_o` stays 0, while `lock_o` is unchanged.
- R8: Powerdown drops lock, forces `drive_en_o` low and clears `err_cnt_o` and the search. After release, a full eight-frame relock is needed.
- R9: After reset: `lock_o`=0, `valid_o`=0, `word_o`=0, `err_cnt_o`=0, and the state is HUNT at offset zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ser_i | input | 1 | Serial data bit |
| bit_en_i | input | 1 | Bit-rate enable, qualifies `ser_i` |
| oe_i | input | 1 | Output enable for word and strobe |
| pwdn_i | input | 1 | Powerdown |
| word_o | output | 24 | Decoded payload word |
| valid_o | output | 1 | One-cycle word strobe |
| lock_o | output | 1 | Frame lock flag |
| drive_en_o | output | 1 | Output drive enable |
| err_cnt_o | output | 8 | Saturating parity error count |

## Verification
Lock, the word, its strobe and the error count all change on the clock edge that takes the last bit of a frame. The bench presents each bit for one enabled cycle, idles for one cycle, and samples on the falling edge after that. A result is therefore read exactly one edge after the frame's final bit, and the strobe is checked low again one cycle later. Lock loss after a missing clock pair or a slip is checked at the end of the first misaligned frame. Relock is checked as absent after seven frames and present after the eighth when the new offset is known. Relock after an arbitrary offset loss is bounded by a frame count.

// File: rtl/ecl_pkg.sv
package ecl_pkg;
    typedef enum logic [1:0] {
        ST_PWRDN  = 2'd0,
        ST_HUNT   = 2'd1,
        ST_LOCKED = 2'd2
    } ecl_state_t;
endpackage

// File: rtl/ecl_shreg.sv
module ecl_shreg #(
    parameter int FW = 28
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          en_i,
    input  logic          din_i,
    output logic [FW-1:0] win_o
);
    logic [FW-1:0] sh_q;

    // window as it will be once the current bit is in; oldest bit on top
    assign win_o = {sh_q[FW-2:0], din_i};

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)   sh_q <= '0;
        else if (en_i) sh_q <= win_o;
    end
endmodule

// File: rtl/ecl_frame_chk.sv
module ecl_frame_chk #(
    parameter int PAY_W = 24,
    localparam int FW   = PAY_W + 4
) (
    input  logic [FW-1:0]    win_i,
    output logic             clk_ok_o,
    output logic             par_ok_o,
    output logic [PAY_W-1:0] pay_o
);
    logic dcb;

    assign clk_ok_o = win_i[FW-1] & ~win_i[FW-2];
    assign par_ok_o = ~(^win_i[FW-3:0]);
    assign dcb      = win_i[1];

    for (genvar i = 0; i < PAY_W; i++) begin : g_pay
        assign pay_o[i] = win_i[FW-3-i] ^ dcb;
    end
endmodule

// File: rtl/ecl_align_ctr.sv
module ecl_align_ctr #(
    parameter int FW   = 28,
    localparam int CW  = $clog2(FW)
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic en_i,
    input  logic restart_i,
    input  logic slip_i,
    output logic fend_o
);
    logic [CW-1:0] cnt_q;
    logic          skip_q;

    assign fend_o = en_i && !skip_q && (cnt_q == CW'(FW - 1));

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q  <= '0;
            skip_q <= 1'b0;
        end else if (restart_i) begin
            cnt_q  <= '0;
            skip_q <= 1'b0;
        end else if (slip_i) begin
            cnt_q  <= '0;
            skip_q <= 1'b1;
        end else if (en_i) begin
            if (skip_q)                      skip_q <= 1'b0;
            else if (cnt_q == CW'(FW - 1))   cnt_q  <= '0;
            else                             cnt_q  <= cnt_q + 1'b1;
        end
    end

    // R2: a slip always lengthens the next window by one bit
    slip_skip_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (slip_i && !restart_i) |=> !fend_o);
endmodule

// File: rtl/ecl_lock_rx.sv
module ecl_lock_rx
    import ecl_pkg::*;
#(
    parameter int PAY_W  = 24,
    parameter int GOOD_N = 8,
    parameter int ERR_W  = 8,
    localparam int FW    = PAY_W + 4,
    localparam int GW    = $clog2(GOOD_N + 1)
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             ser_i,
    input  logic             bit_en_i,
    input  logic             oe_i,
    input  logic             pwdn_i,
    output logic [PAY_W-1:0] word_o,
    output logic             valid_o,
    output logic             lock_o,
    output logic             drive_en_o,
    output logic [ERR_W-1:0] err_cnt_o
);
    localparam logic [ERR_W-1:0] ERR_MAX = '1;

    ecl_state_t       state_q, state_n;
    logic [FW-1:0]    win;
    logic             clk_ok, par_ok, frame_ok, fend, slip, restart;
    logic [PAY_W-1:0] pay;
    logic [GW-1:0]    good_q;
    logic [PAY_W-1:0] word_q;
    logic             valid_q, lock_q;
    logic [ERR_W-1:0] err_q;

    ecl_shreg #(.FW(FW)) u_shreg (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .en_i   (bit_en_i),
        .din_i  (ser_i),
        .win_o  (win)
    );

    ecl_frame_chk #(.PAY_W(PAY_W)) u_chk (
        .win_i    (win),
        .clk_ok_o (clk_ok),
        .par_ok_o (par_ok),
        .pay_o    (pay)
    );

    assign frame_ok = clk_ok & par_ok;
    assign restart  = pwdn_i | (state_q == ST_PWRDN);
    assign slip     = fend && (((state_q == ST_HUNT) && !frame_ok) ||
                               ((state_q == ST_LOCKED) && !clk_ok));

    ecl_align_ctr #(.FW(FW)) u_align (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .en_i      (bit_en_i),
        .restart_i (restart),
        .slip_i    (slip),
        .fend_o    (fend)
    );

    always_comb begin
        state_n = state_q;
        if (pwdn_i) begin
            state_n = ST_PWRDN;
        end else begin
            unique case (state_q)
                ST_PWRDN:  state_n = ST_HUNT;
                ST_HUNT:   if (fend && frame_ok && good_q == GW'(GOOD_N - 1))
                               state_n = ST_LOCKED;
                ST_LOCKED: if (fend && !clk_ok)
                               state_n = ST_HUNT;
                default:   state_n = ST_HUNT;
            endcase
        end
    end

    // state register and run counter
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= ST_HUNT;
            good_q  <= '0;
        end else begin
            state_q <= state_n;
            if (pwdn_i || state_q != ST_HUNT) good_q <= '0;
            else if (fend)                    good_q <= frame_ok ? good_q + 1'b1 : '0;
        end
    end

    // registered outputs
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            lock_q  <= 1'b0;
            valid_q <= 1'b0;
            word_q  <= '0;
            err_q   <= '0;
        end else begin
            lock_q  <= (state_n == ST_LOCKED);
            valid_q <= fend && (state_n == ST_LOCKED);
            if (fend && state_n == ST_LOCKED) word_q <= pay;
            if (pwdn_i)
                err_q <= '0;
            else if (state_q == ST_LOCKED && fend && clk_ok && !par_ok && err_q != ERR_MAX)
                err_q <= err_q + 1'b1;
        end
    end

    assign drive_en_o = oe_i & ~pwdn_i;
    assign word_o     = drive_en_o ? word_q : '0;
    assign valid_o    = valid_q & drive_en_o;
    assign lock_o     = lock_q;
    assign err_cnt_o  = err_q;

    // R2
    lock_after_run_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(lock_q) |-> ($past(good_q) == GW'(GOOD_N - 1)));
    // R3
    lock_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_LOCKED && fend && !clk_ok) |=> !lock_q);
    // R4
    valid_lock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        valid_q |-> lock_q);
    // R6
    err_sat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (err_q == ERR_MAX && !pwdn_i) |=> (err_q == ERR_MAX));
    // R8
    pwdn_unlock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pwdn_i |=> (!lock_q && err_q == '0));
endmodule

// File: tb/sim_ecl_lock_rx.sv
module sim_ecl_lock_rx;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ser = 1'b0, ben = 1'b0, oe = 1'b1, pwdn = 1'b0;
    logic [23:0] word;
    logic        valid, lock, drive_en;
    logic [7:0]  err;

    int checks = 0, fails = 0, fidx = 0;
    logic [23:0] last_p;
    logic done = 1'b0;

    always #5 clk = ~clk;

    ecl_lock_rx u0 (
        .clk_i(clk), .rst_ni(rst_n), .ser_i(ser), .bit_en_i(ben),
        .oe_i(oe), .pwdn_i(pwdn), .word_o(word), .valid_o(valid),
        .lock_o(lock), .drive_en_o(drive_en), .err_cnt_o(err)
    );

    // {payload, sent-inverted}
    localparam logic [24:0] VEC [8] = '{
        {24'hA5C3F0, 1'b0}, {24'hA5C3F0, 1'b1}, {24'h000000, 1'b1}, {24'hFFFFFF, 1'b0},
        {24'h800001, 1'b1}, {24'h123456, 1'b0}, {24'hFEDCBA, 1'b1}, {24'h0F0F0F, 1'b0}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic send_bit(input logic b);
        @(negedge clk); ser = b; ben = 1'b1;
        @(negedge clk); ben = 1'b0;
    endtask

    task automatic send_frame(input logic [23:0] p, input logic inv,
                              input logic bad_par, input logic bad_clk);
        logic [23:0] tp;
        tp = inv ? ~p : p;
        send_bit(~bad_clk);
        send_bit(1'b0);
        for (int i = 0; i < 24; i++) send_bit(tp[i]);
        send_bit(inv);
        send_bit((^tp) ^ inv ^ bad_par);
        last_p = p;
    endtask

    function automatic logic [23:0] gen_p(input int f);
        return (24'(f) * 24'h9E3779) ^ 24'h5A5A5A;
    endfunction

    task automatic good_frame();
        send_frame(gen_p(fidx), fidx[0], 1'b0, 1'b0);
        fidx++;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R9 reset state
        chk("R9 lock", lock, 0);
        chk("R9 valid", valid, 0);
        chk("R9 word", word, 0);
        chk("R9 err", err, 0);
        chk("R9 drive_en", drive_en, 1);

        // R1 R2: aligned stream, eight good frames needed
        repeat (7) good_frame();
        chk("R2 no lock after 7", lock, 0);
        good_frame();
        chk("R4 lock with first word", lock, 1);
        chk("R4 valid with lock", valid, 1);
        chk("R1 first word", word, last_p);
        @(negedge clk);
        chk("R4 strobe one cycle", valid, 0);

        // R5 table walk, mixed inversion
        for (int v = 0; v < 8; v++) begin
            send_frame(VEC[v][24:1], VEC[v][0], 1'b0, 1'b0);
            chk("R5 word", word, VEC[v][24:1]);
            chk("R5 valid", valid, 1);
        end

        // R6 parity error keeps lock
        send_frame(24'h3C3C3C, 1'b0, 1'b1, 1'b0);
        chk("R6 lock kept", lock, 1);
        chk("R6 err count", err, 1);
        chk("R6 word delivered", word, 24'h3C3C3C);

        // R7 output enable
        oe = 1'b0;
        good_frame();
        chk("R7 drive_en", drive_en, 0);
        chk("R7 valid gated", valid, 0);
        chk("R7 word gated", word, 0);
        chk("R7 lock kept", lock, 1);
        oe = 1'b1;
        good_frame();
        chk("R7 valid back", valid, 1);
        chk("R7 word back", word, last_p);

        // R3 one-bit slip: extra zero bit
        send_bit(1'b0);
        good_frame();
        chk("R3 lock lost within a frame", lock, 0);
        repeat (7) good_frame();
        chk("R3 no lock after 7 at new offset", lock, 0);
        good_frame();
        chk("R3 relock at new offset", lock, 1);
        chk("R3 word at new offset", word, last_p);

        // R3 missing clock edge, then bounded relock from a shifted offset
        send_frame(24'h55AA55, 1'b0, 1'b0, 1'b1);
        chk("R3 missing clock drops lock", lock, 0);
        for (int k = 0; k < 100 && !lock; k++) good_frame();
        chk("R2 relock after search", lock, 1);
        chk("R2 word after search", word, last_p);

        // R8 powerdown
        pwdn = 1'b1;
        repeat (2) @(negedge clk);
        chk("R8 lock low", lock, 0);
        chk("R8 drive_en low", drive_en, 0);
        chk("R8 err cleared", err, 0);
        pwdn = 1'b0;
        @(negedge clk);
        repeat (7) good_frame();
        chk("R8 no early relock", lock, 0);
        good_frame();
        chk("R8 relock after 8", lock, 1);

        // R6 saturation
        for (int k = 0; k < 260; k++) send_frame(gen_p(k), k[0], 1'b1, 1'b0);
        chk("R6 err saturates", err, 8'hFF);
        chk("R6 lock after errors", lock, 1);

        finish_run();
    end
endmodule